// File: doc/BRIEF.md
# Dual Output Compare Unit

This block watches a free-running timer count and raises a match flag when the count equals a programmed compare value. It works beside an external counter. The counter supplies its current value and a one-cycle timer-clock enable that marks the cycles on which it advances. The block produces two sticky match flags and, for each flag, an interrupt request gated by its own enable.

The block has two modes. In byte mode there are two independent compare channels. Each channel compares the low byte of the count with its own compare register and drives its own flag. In word mode the two registers form one 16-bit compare value, and only the first flag can be set. A match does not set its flag at once: it is captured on a timer-clock cycle and reaches the flag on the next timer-clock cycle. Software can clear a flag by writing a one to its clear input. The interrupt controller clears a flag by pulsing its acknowledge input.

Top module: `ocmp_dual_unit`

## Requirements
- R1: In byte mode (`wideMode`=0), channel A compares `count[7:0]` with `cmpA` and channel B compares `count[7:0]` with `cmpB`. `count[15:8]` has no effect on either channel.
- R2: An equality seen on a clock edge where `tmrTick`=1 sets the flag on the next clock edge where `tmrTick`=1, and not earlier.
- R3: In byte mode, a match on `cmpA` sets only `flagA` and a match on `cmpB` sets only `flagB`.
- R4: In word mode (`wideMode`=1), the compare value is `{cmpB, cmpA}`, with `cmpB` as the high byte, and it is compared with all 16 bits of `count`. Only `flagA` can be set. `flagB` never rises on an edge where `wideMode` is 1, and this includes a B match captured earlier in byte mode.
- R5: `irqA` is 1 exactly when `flagA`=1 and `ieA`=1. `irqB` follows the same rule with `flagB` and `ieB`.
- R6: A 1 on `ackA` or `ackB` clears that flag at the next clock edge.
- R7: A 1 on `clrA` or `clrB` clears that flag at the next clock edge. A 0 on these inputs has no effect.
- R8: When a flag is set and cleared on the same edge, the set wins and the flag reads 1.
- R9: Equality on edges where `tmrTick`=0 is ignored. Without a clear or acknowledge, a flag holds its value across those edges.
- R10: While `rstN`=0, both flags, both interrupt requests and the captured matches are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tmrTick | input | 1 | Timer-clock enable from the counter |
| count | input | 16 | Current timer count |
| cmpA | input | 8 | Compare register A (low byte in word mode) |
| cmpB | input | 8 | Compare register B (high byte in word mode) |
| wideMode | input | 1 | 0 = two byte channels, 1 = one 16-bit channel |
| ieA | input | 1 | Interrupt enable for flag A |
| ieB | input | 1 | Interrupt enable for flag B |
| clrA | input | 1 | Write-one clear of flag A |
| clrB | input | 1 | Write-one clear of flag B |
| ackA | input | 1 | Interrupt-serviced clear of flag A |
| ackB | input | 1 | Interrupt-serviced clear of flag B |
| flagA | output | 1 | Match flag A |
| flagB | output | 1 | Match flag B |
| irqA | output | 1 | Compare interrupt request A |
| irqB | output | 1 | Compare interrupt request B |

## Verification
A flag being set by a captured match and cleared by a write-one or an acknowledge can fall on the same timer-clock edge. The other pair that can collide is a B match captured in byte mode and a switch to word mode before that match is delivered. The bench provokes both by running phases with high rates of clear, acknowledge and mode change, while it steers the count onto the compare values. A reference model built from the requirements judges every cycle: the set must win, and the stale B match must never appear once word mode is active.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic capture;  // sample equality into the pending stage
    logic setA;     // deliver pending match to flag A
    logic setB;     // deliver pending match to flag B
    logic dropA;    // clear request for flag A
    logic dropB;    // clear request for flag B
  } ocStrobe_t;
endpackage

// File: rtl/ocmp_datapath.sv
module ocmp_datapath
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2*W-1:0] count,
  input  logic [W-1:0]   cmpA,
  input  logic [W-1:0]   cmpB,
  input  logic           wideMode,
  input  ocStrobe_t      strobe,
  output logic           pendA,
  output logic           pendB,
  output logic           flagA,
  output logic           flagB
);
  localparam int CW = 2 * W;

  logic [CW-1:0] wideRef;
  logic          eqLowA, eqLowB, eqWide;
  logic          eqA, eqB;

  assign wideRef = {cmpB, cmpA};
  assign eqLowA  = (count[W-1:0] == cmpA);
  assign eqLowB  = (count[W-1:0] == cmpB);
  assign eqWide  = (count == wideRef);
  assign eqA     = wideMode ? eqWide : eqLowA;
  assign eqB     = !wideMode && eqLowB;

  // Pending stage: equality seen on a timer-clock cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendA <= 1'b0;
      pendB <= 1'b0;
    end else if (strobe.capture) begin
      pendA <= eqA;
      pendB <= eqB;
    end
  end

  // Sticky flags, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      if (strobe.setA)       flagA <= 1'b1;
      else if (strobe.dropA) flagA <= 1'b0;
      if (strobe.setB)       flagB <= 1'b1;
      else if (strobe.dropB) flagB <= 1'b0;
    end
  end
endmodule

// File: rtl/ocmp_control.sv
module ocmp_control
  import ocmp_pkg::*;
(
  input  logic      tmrTick,
  input  logic      wideMode,
  input  logic      pendA,
  input  logic      pendB,
  input  logic      clrA,
  input  logic      clrB,
  input  logic      ackA,
  input  logic      ackB,
  output ocStrobe_t strobe
);
  always_comb begin
    strobe.capture = tmrTick;
    strobe.setA    = tmrTick && pendA;
    // a B match captured in byte mode is not delivered once word mode is on
    strobe.setB    = tmrTick && pendB && !wideMode;
    strobe.dropA   = clrA || ackA;
    strobe.dropB   = clrB || ackB;
  end
endmodule

// File: rtl/ocmp_dual_unit.sv
module ocmp_dual_unit
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tmrTick,
  input  logic [2*W-1:0] count,
  input  logic [W-1:0]   cmpA,
  input  logic [W-1:0]   cmpB,
  input  logic           wideMode,
  input  logic           ieA,
  input  logic           ieB,
  input  logic           clrA,
  input  logic           clrB,
  input  logic           ackA,
  input  logic           ackB,
  output logic           flagA,
  output logic           flagB,
  output logic           irqA,
  output logic           irqB
);
  ocStrobe_t strobe;
  logic      pendA, pendB;

  ocmp_control u_ctl (
    .tmrTick (tmrTick),
    .wideMode(wideMode),
    .pendA   (pendA),
    .pendB   (pendB),
    .clrA    (clrA),
    .clrB    (clrB),
    .ackA    (ackA),
    .ackB    (ackB),
    .strobe  (strobe)
  );

  ocmp_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .count   (count),
    .cmpA    (cmpA),
    .cmpB    (cmpB),
    .wideMode(wideMode),
    .strobe  (strobe),
    .pendA   (pendA),
    .pendB   (pendB),
    .flagA   (flagA),
    .flagB   (flagB)
  );

  assign irqA = flagA && ieA;
  assign irqB = flagB && ieB;
endmodule

// File: rtl/ocmp_dual_unit_chk.sv
module ocmp_dual_unit_chk (
  input logic clk,
  input logic rstN,
  input logic tmrTick,
  input logic wideMode,
  input logic clrA,
  input logic clrB,
  input logic ackA,
  input logic ackB,
  input logic flagA,
  input logic flagB,
  input logic irqA,
  input logic irqB
);
  // R2: a flag can only rise on an edge where the timer clock was enabled
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(flagA) && flagA) |-> $past(tmrTick));

  // R4: flag B never rises on an edge taken in word mode
  p_no_b_wide_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wideMode) && !$past(flagB)) |-> !flagB);

  // R5: a request needs its flag
  p_irq_a_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> flagA);
  p_irq_b_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> flagB);

  // R6: acknowledge without a timer tick leaves the flag cleared
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ackA) && !$past(tmrTick)) |-> !flagA);

  // R7: write-one clear without a timer tick leaves the flag cleared
  p_clr_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrB) && !$past(tmrTick)) |-> !flagB);

  // R9: off-tick edges with no clear hold the flag
  p_hold_off_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tmrTick) && !$past(clrA) && !$past(ackA)) |-> $stable(flagA));
endmodule

bind ocmp_dual_unit ocmp_dual_unit_chk u_chk (.*);

// File: tb/tb_ocmp_dual_unit.sv
module tb_ocmp_dual_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrTick = 1'b0;
  logic [15:0] count = '0;
  logic [7:0]  cmpA = '0, cmpB = '0;
  logic        wideMode = 1'b0;
  logic        ieA = 1'b0, ieB = 1'b0;
  logic        clrA = 1'b0, clrB = 1'b0, ackA = 1'b0, ackB = 1'b0;
  logic        flagA, flagB, irqA, irqB;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic mPendA = 1'b0, mPendB = 1'b0, mFlagA = 1'b0, mFlagB = 1'b0;

  always #5 clk = ~clk;

  ocmp_dual_unit dut (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .count(count),
    .cmpA(cmpA), .cmpB(cmpB), .wideMode(wideMode),
    .ieA(ieA), .ieB(ieB), .clrA(clrA), .clrB(clrB),
    .ackA(ackA), .ackB(ackB),
    .flagA(flagA), .flagB(flagB), .irqA(irqA), .irqB(irqB)
  );

  function automatic logic expEqA(logic [15:0] c, logic [7:0] a, logic [7:0] b, logic w);
    return w ? (c == {b, a}) : (c[7:0] == a);
  endfunction

  function automatic logic expEqB(logic [15:0] c, logic [7:0] b, logic w);
    return !w && (c[7:0] == b);
  endfunction

  function automatic logic nextFlag(logic cur, logic setIt, logic clrIt);
    return setIt ? 1'b1 : (clrIt ? 1'b0 : cur);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPendA <= 1'b0; mPendB <= 1'b0; mFlagA <= 1'b0; mFlagB <= 1'b0;
    end else begin
      mFlagA <= nextFlag(mFlagA, tmrTick && mPendA, clrA || ackA);
      mFlagB <= nextFlag(mFlagB, tmrTick && mPendB && !wideMode, clrB || ackB);
      if (tmrTick) begin
        mPendA <= expEqA(count, cmpA, cmpB, wideMode);
        mPendB <= expEqB(count, cmpB, wideMode);
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "flagA", flagA, mFlagA);
    chk(req, "flagB", flagB, mFlagB);
    chk(req, "irqA", irqA, mFlagA && ieA);
    chk(req, "irqB", irqB, mFlagB && ieB);
  endtask

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  // n cycles of random stimulus; count steered onto compare values
  task automatic runPhase(string req, int n, int tickPct, int clrPct, int ackPct,
                          int widePct, int hitPct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkAll(req);
      tmrTick  = pct(tickPct);
      wideMode = pct(widePct);
      clrA = pct(clrPct); clrB = pct(clrPct);
      ackA = pct(ackPct); ackB = pct(ackPct);
      ieA = pct(50); ieB = pct(50);
      if (pct(5)) begin
        cmpA = 8'($urandom); cmpB = 8'($urandom);
      end
      count = 16'($urandom);
      if (pct(hitPct)) begin
        case ($urandom % 3)
          0: count[7:0] = cmpA;
          1: count[7:0] = cmpB;
          default: count = {cmpB, cmpA};
        endcase
      end
    end
  endtask

  task automatic idleCycle(string req);
    @(negedge clk);
    checkAll(req);
    tmrTick = 1'b0; clrA = 1'b0; clrB = 1'b0; ackA = 1'b0; ackB = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R10: reset state
    repeat (3) @(negedge clk);
    checkAll("R10");
    chk("R10", "flagA rst", flagA, 1'b0);
    chk("R10", "irqB rst", irqB, 1'b0);
    rstN = 1'b1;

    // R2: directed delayed set, byte mode
    cmpA = 8'h05; cmpB = 8'h80; ieA = 1'b1; ieB = 1'b1;
    @(negedge clk); checkAll("R2");
    count = 16'hAB05; tmrTick = 1'b1;           // captured on this edge
    @(negedge clk); checkAll("R2");
    chk("R2", "flagA not yet", flagA, 1'b0);
    count = 16'h0006; tmrTick = 1'b0;           // no tick: no delivery
    @(negedge clk); checkAll("R2");
    chk("R2", "flagA waits tick", flagA, 1'b0);
    tmrTick = 1'b1;                              // delivered here
    @(negedge clk); checkAll("R2");
    chk("R2", "flagA set", flagA, 1'b1);
    chk("R5", "irqA set", irqA, 1'b1);
    chk("R3", "flagB untouched", flagB, 1'b0);
    tmrTick = 1'b0; ieA = 1'b0;
    @(negedge clk);
    chk("R5", "irqA masked", irqA, 1'b0);
    clrA = 1'b0; ackA = 1'b0;                    // R7: zero write
    @(negedge clk);
    chk("R7", "zero clear ignored", flagA, 1'b1);
    clrA = 1'b1;
    @(negedge clk);
    chk("R7", "clear", flagA, 1'b0);
    clrA = 1'b0;

    // R4: stale B match dropped on switch to word mode
    count = 16'h0080; tmrTick = 1'b1;            // B captured in byte mode
    @(negedge clk); checkAll("R4");
    wideMode = 1'b1; count = 16'h1111;
    @(negedge clk); checkAll("R4");
    chk("R4", "stale B dropped", flagB, 1'b0);
    count = 16'h8005;                            // {cmpB,cmpA}
    @(negedge clk); checkAll("R4");
    count = 16'h0000;
    @(negedge clk); checkAll("R4");
    chk("R4", "word match A", flagA, 1'b1);
    ackA = 1'b1; tmrTick = 1'b0;
    @(negedge clk);
    chk("R6", "ack clears", flagA, 1'b0);
    idleCycle("R6");

    // R8: set and clear on the same edge
    wideMode = 1'b0; count = 16'h0005; tmrTick = 1'b1;
    @(negedge clk); checkAll("R8");
    clrA = 1'b1; count = 16'h0000;
    @(negedge clk); checkAll("R8");
    chk("R8", "set wins", flagA, 1'b1);
    idleCycle("R8");

    runPhase("R1", 400, 70, 5, 5, 0, 60);
    runPhase("R3", 400, 80, 8, 8, 0, 70);
    runPhase("R4", 400, 80, 8, 8, 70, 70);
    runPhase("R9", 400, 15, 3, 3, 20, 80);
    runPhase("R6", 300, 60, 0, 40, 20, 70);
    runPhase("R7", 300, 60, 40, 0, 20, 70);
    runPhase("R8", 400, 90, 50, 30, 30, 90);
    runPhase("R5", 300, 70, 10, 10, 30, 70);

    // R10: reset in the middle of activity
    rstN = 1'b0;
    @(negedge clk); checkAll("R10");
    chk("R10", "flagB in reset", flagB, 1'b0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule